// File: doc/BRIEF.md
# Serial Flash Erase Command Sequencer

This block is the slave-side command logic of a serial NOR flash that handles erase traffic. A host drives SPI mode 0 frames (clock idles low, data sampled on the rising edge) framed by an active-low select. The block decodes four commands: set the write-enable latch, erase one block, erase the whole array, and read the status byte. It keeps two status flags, write-enable and busy. It also enforces the rule that a command takes effect only when the select is released exactly after its last whole byte. Every SPI input passes through a synchronizer and is oversampled by the system clock, so the host clock must run several times slower than the system clock.

An accepted erase starts on the release of the select. The busy flag stays set for a fixed number of system clocks. During that time a walker writes all-ones into every byte of the target region, one word per clock. A per-block protect mask can veto a block erase, and any set protect bit vetoes a full-array erase. The array is a small synchronous RAM with a registered read port. It also has a load port, so a test or model can seed its contents while no erase is running.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset the status byte reads 0x00 and `spi_miso` is low while `spi_cs_n` is high.
- R2: A frame of exactly one byte 0x06 sets the write-enable flag, which is bit 1 of the status byte.
- R3: After the opcode byte 0x05, the status byte is shifted out MSB first on `spi_miso` and repeats for each further byte. It changes after falling clock edges and is valid at rising edges. Bit 0 is busy, bit 1 is write-enable and bits 7..2 are zero. It can be read while an erase runs.
- R4: Opcode 0xD8 followed by three address bytes (MSB first) erases one block when write-enable is set. The block index is address bits [BLK_SHIFT+log2(NBLK)-1:BLK_SHIFT], which are bits [17:16] by default. Every byte of that block becomes 0xFF and all other bytes are unchanged.
- R5: A one-byte frame of 0xC7 or 0x60 with write-enable set turns every byte of the array to 0xFF, provided that no protect bit is set.
- R6: A block or chip erase sent while write-enable is clear has no effect on the array or the status.
- R7: A command is accepted only if the select rises after exactly its full byte count: 1 byte for 0x06, 0xC7 and 0x60, and 4 bytes for 0xD8. Extra or missing bytes, or trailing partial bits, leave the write-enable flag and the array unchanged.
- R8: Busy rises on the release that accepts an erase and stays set for ERASE_CYC system clocks. When it clears, write-enable clears in the same cycle.
- R9: A block erase aimed at a block whose `blk_protect` bit is set is not executed, and write-enable stays set. A chip erase is not executed while any protect bit is set.
- R10: While busy is set, every command except the status read is ignored.
- R11: `ld_we` writes `ld_data` to `ld_addr` when the block is not busy. `rd_data` shows the byte at `rd_addr` one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | SPI clock from host, mode 0 |
| spi_cs_n | input | 1 | Active-low select from host |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial status data to host |
| blk_protect | input | NBLK | One protect bit per block, bit index equals block index |
| ld_we | input | 1 | Array load strobe (ignored while busy) |
| ld_addr | input | log2(NBLK*WPB) | Array load word address |
| ld_data | input | 8 | Array load data |
| rd_addr | input | log2(NBLK*WPB) | Array read word address |
| rd_data | output | 8 | Registered array read data |

## Verification
The hardest situations to reach from the ports are a command that lands while an erase is running and a select released in the middle of a byte. In both cases the frame looks normal to the serial logic, and only the acceptance gate decides the outcome. The bench starts an erase and then issues a write-enable and a second block erase to a different block before the erase ends. It then checks that the second block keeps its seeded contents. Random iterations perturb the byte count by one and append one to seven stray bits. The protect mask and the write-enable state are varied at the same time, so each rejection path is hit alongside the accepting paths.

// File: rtl/fes_pkg.sv
package fes_pkg;
  localparam logic [7:0] OP_SET_WE     = 8'h06;
  localparam logic [7:0] OP_BLK_ERASE  = 8'hD8;
  localparam logic [7:0] OP_CHIP_ERA_A = 8'hC7;
  localparam logic [7:0] OP_CHIP_ERA_B = 8'h60;
  localparam logic [7:0] OP_GET_STAT   = 8'h05;
  localparam int ST_BUSY_BIT = 0;
  localparam int ST_WE_BIT   = 1;
endpackage

// File: rtl/fes_spi_port.sv
module fes_spi_port #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sck,
  input  logic       cs_n,
  input  logic       mosi,
  input  logic       tx_en,
  input  logic [7:0] tx_byte,
  output logic       cs_active,
  output logic       cs_rise,
  output logic       byte_vld,
  output logic [7:0] rx_byte,
  output logic       at_boundary,
  output logic       miso
);
  logic [SYNC_STAGES-1:0] sck_sh, cs_sh, mosi_sh;
  logic sck_s, cs_s, mosi_s, sck_d, cs_d;
  logic [2:0] bit_cnt;
  logic [6:0] rx_sr;
  logic [7:0] tx_sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_sh  <= '0;
      cs_sh   <= '1;
      mosi_sh <= '0;
    end else begin
      sck_sh  <= {sck_sh[SYNC_STAGES-2:0], sck};
      cs_sh   <= {cs_sh[SYNC_STAGES-2:0], cs_n};
      mosi_sh <= {mosi_sh[SYNC_STAGES-2:0], mosi};
    end
  end

  assign sck_s       = sck_sh[SYNC_STAGES-1];
  assign cs_s        = cs_sh[SYNC_STAGES-1];
  assign mosi_s      = mosi_sh[SYNC_STAGES-1];
  assign cs_active   = ~cs_s;
  assign cs_rise     = cs_s & ~cs_d;
  assign at_boundary = (bit_cnt == 3'd0);

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_d    <= 1'b0;
      cs_d     <= 1'b1;
      bit_cnt  <= '0;
      rx_sr    <= '0;
      tx_sr    <= '0;
      rx_byte  <= '0;
      byte_vld <= 1'b0;
      miso     <= 1'b0;
    end else begin
      sck_d    <= sck_s;
      cs_d     <= cs_s;
      byte_vld <= 1'b0;
      if (cs_s) begin
        bit_cnt <= '0;
        miso    <= 1'b0;
      end else begin
        if (sck_s && !sck_d) begin
          rx_sr   <= {rx_sr[5:0], mosi_s};
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7) begin
            byte_vld <= 1'b1;
            rx_byte  <= {rx_sr, mosi_s};
          end
        end
        if (!sck_s && sck_d) begin
          if (!tx_en) begin
            miso <= 1'b0;
          end else if (bit_cnt == 3'd0) begin
            tx_sr <= tx_byte;
            miso  <= tx_byte[7];
          end else begin
            miso <= tx_sr[3'd7 - bit_cnt];
          end
        end
      end
    end
  end

  // R3: output is quiet once the select is released
  a_r3_miso_quiet: assert property (@(posedge clk) disable iff (rst)
    cs_s |=> !miso);
endmodule

// File: rtl/fes_cmd_ctl.sv
module fes_cmd_ctl
  import fes_pkg::*;
#(
  parameter int NBLK       = 4,
  parameter int BLK_SHIFT  = 16,
  parameter int ADDR_BYTES = 3,
  parameter int ERASE_CYC  = 2000
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cs_active,
  input  logic                     cs_rise,
  input  logic                     at_boundary,
  input  logic                     byte_vld,
  input  logic [7:0]               rx_byte,
  input  logic [NBLK-1:0]          blk_protect,
  input  logic                     walk_busy,
  output logic                     tx_en,
  output logic [7:0]               tx_byte,
  output logic                     wip,
  output logic                     wel,
  output logic                     erase_start,
  output logic                     erase_chip,
  output logic [$clog2(NBLK)-1:0]  erase_blk
);
  localparam int AB_W     = 8 * ADDR_BYTES;
  localparam int BLK_W    = $clog2(NBLK);
  localparam int TMR_W    = $clog2(ERASE_CYC + 1);
  localparam int FRAME_BE = 1 + ADDR_BYTES;

  logic [7:0]       opcode;
  logic [2:0]       nbytes;
  logic [AB_W-1:0]  addr;
  logic [TMR_W-1:0] tmr;
  logic [BLK_W-1:0] blk_sel;
  logic             ok_one, ok_be, is_chip, addr_unused;

  assign blk_sel     = addr[BLK_SHIFT +: BLK_W];
  assign addr_unused = ^{addr[BLK_SHIFT-1:0], addr[AB_W-1:BLK_SHIFT+BLK_W]};
  assign ok_one      = at_boundary && (nbytes == 3'd1);
  assign ok_be       = at_boundary && (nbytes == 3'(FRAME_BE));
  assign is_chip     = (opcode == OP_CHIP_ERA_A) || (opcode == OP_CHIP_ERA_B);
  assign tx_en       = cs_active && (nbytes != 3'd0) && (opcode == OP_GET_STAT);

  always_comb begin
    tx_byte              = '0;
    tx_byte[ST_BUSY_BIT] = wip;
    tx_byte[ST_WE_BIT]   = wel;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      opcode      <= '0;
      nbytes      <= '0;
      addr        <= '0;
      tmr         <= '0;
      wip         <= 1'b0;
      wel         <= 1'b0;
      erase_start <= 1'b0;
      erase_chip  <= 1'b0;
      erase_blk   <= '0;
    end else begin
      erase_start <= 1'b0;
      if (cs_rise || !cs_active) begin
        nbytes <= '0;
      end else if (byte_vld) begin
        if (nbytes == 3'd0) opcode <= rx_byte;
        else                addr   <= {addr[AB_W-9:0], rx_byte};
        if (nbytes != 3'd7) nbytes <= nbytes + 3'd1;
      end
      if (wip) begin
        if (tmr != TMR_W'(ERASE_CYC - 1)) begin
          tmr <= tmr + 1'b1;
        end else if (!walk_busy) begin
          wip <= 1'b0;
          wel <= 1'b0;
        end
      end else if (cs_rise) begin
        if (opcode == OP_SET_WE && ok_one) begin
          wel <= 1'b1;
        end else if (opcode == OP_BLK_ERASE && ok_be && wel && !blk_protect[blk_sel]) begin
          wip         <= 1'b1;
          tmr         <= '0;
          erase_start <= 1'b1;
          erase_chip  <= 1'b0;
          erase_blk   <= blk_sel;
        end else if (is_chip && ok_one && wel && (blk_protect == '0)) begin
          wip         <= 1'b1;
          tmr         <= '0;
          erase_start <= 1'b1;
          erase_chip  <= 1'b1;
        end
      end
    end
  end

  // R8: completion clears write-enable together with busy
  a_r8_done_clears_we: assert property (@(posedge clk) disable iff (rst)
    $fell(wip) |-> !wel);
  // R6: no erase starts without write-enable
  a_r6_start_needs_we: assert property (@(posedge clk) disable iff (rst)
    $rose(wip) |-> $past(wel));
  // R7: an erase starts only on a select release at a byte boundary
  a_r7_start_on_boundary: assert property (@(posedge clk) disable iff (rst)
    $rose(wip) |-> $past(cs_rise && at_boundary));
  // R10: write-enable cannot be set while busy
  a_r10_we_frozen_busy: assert property (@(posedge clk) disable iff (rst)
    ($past(wip) && wip) |-> $stable(wel));
endmodule

// File: rtl/fes_array.sv
module fes_array #(
  parameter int NBLK = 4,
  parameter int WPB  = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          erase_start,
  input  logic                          erase_chip,
  input  logic [$clog2(NBLK)-1:0]       erase_blk,
  output logic                          walk_busy,
  output logic [$clog2(NBLK*WPB)-1:0]   walk_ptr,
  input  logic                          ld_en,
  input  logic [$clog2(NBLK*WPB)-1:0]   ld_addr,
  input  logic [7:0]                    ld_data,
  input  logic [$clog2(NBLK*WPB)-1:0]   rd_addr,
  output logic [7:0]                    rd_data
);
  localparam int DEPTH = NBLK * WPB;
  localparam int AW    = $clog2(DEPTH);
  localparam int WPB_W = $clog2(WPB);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] last;

  always_ff @(posedge clk) begin
    if (rst) begin
      walk_busy <= 1'b0;
      walk_ptr  <= '0;
      last      <= '0;
    end else if (erase_start) begin
      walk_busy <= 1'b1;
      walk_ptr  <= erase_chip ? '0 : {erase_blk, {WPB_W{1'b0}}};
      last      <= erase_chip ? AW'(DEPTH - 1) : {erase_blk, {WPB_W{1'b1}}};
    end else if (walk_busy) begin
      if (walk_ptr == last) walk_busy <= 1'b0;
      else                  walk_ptr  <= walk_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (walk_busy)  mem[walk_ptr] <= 8'hFF;
    else if (ld_en) mem[ld_addr]  <= ld_data;
  end

  always_ff @(posedge clk) rd_data <= mem[rd_addr];
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq #(
  parameter int NBLK        = 4,
  parameter int WPB         = 4,
  parameter int BLK_SHIFT   = 16,
  parameter int ERASE_CYC   = 2000,
  parameter int SYNC_STAGES = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         spi_sck,
  input  logic                         spi_cs_n,
  input  logic                         spi_mosi,
  output logic                         spi_miso,
  input  logic [NBLK-1:0]              blk_protect,
  input  logic                         ld_we,
  input  logic [$clog2(NBLK*WPB)-1:0]  ld_addr,
  input  logic [7:0]                   ld_data,
  input  logic [$clog2(NBLK*WPB)-1:0]  rd_addr,
  output logic [7:0]                   rd_data
);
  localparam int AW    = $clog2(NBLK * WPB);
  localparam int BLK_W = $clog2(NBLK);
  localparam int WPB_W = $clog2(WPB);

  logic cs_active, cs_rise, byte_vld, at_boundary, tx_en;
  logic [7:0] rx_byte, tx_byte;
  logic wip, wel, erase_start, erase_chip, walk_busy;
  logic [BLK_W-1:0] erase_blk;
  logic [AW-1:0] walk_ptr;

  fes_spi_port #(.SYNC_STAGES(SYNC_STAGES)) u_spi (
    .clk(clk), .rst(rst), .sck(spi_sck), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .tx_en(tx_en), .tx_byte(tx_byte), .cs_active(cs_active), .cs_rise(cs_rise),
    .byte_vld(byte_vld), .rx_byte(rx_byte), .at_boundary(at_boundary), .miso(spi_miso)
  );

  fes_cmd_ctl #(.NBLK(NBLK), .BLK_SHIFT(BLK_SHIFT), .ADDR_BYTES(3), .ERASE_CYC(ERASE_CYC)) u_ctl (
    .clk(clk), .rst(rst), .cs_active(cs_active), .cs_rise(cs_rise),
    .at_boundary(at_boundary), .byte_vld(byte_vld), .rx_byte(rx_byte),
    .blk_protect(blk_protect), .walk_busy(walk_busy), .tx_en(tx_en), .tx_byte(tx_byte),
    .wip(wip), .wel(wel), .erase_start(erase_start), .erase_chip(erase_chip),
    .erase_blk(erase_blk)
  );

  fes_array #(.NBLK(NBLK), .WPB(WPB)) u_arr (
    .clk(clk), .rst(rst), .erase_start(erase_start), .erase_chip(erase_chip),
    .erase_blk(erase_blk), .walk_busy(walk_busy), .walk_ptr(walk_ptr),
    .ld_en(ld_we && !wip), .ld_addr(ld_addr), .ld_data(ld_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // R9: the erase walker never touches a protected block
  a_r9_protected_untouched: assert property (@(posedge clk) disable iff (rst)
    walk_busy |-> !blk_protect[walk_ptr[AW-1:WPB_W]]);
  // R8: array writes from an erase happen only inside the busy window
  a_r8_walk_inside_busy: assert property (@(posedge clk) disable iff (rst)
    walk_busy |-> wip);
endmodule

// File: tb/flash_erase_seq_tb_top.sv
module flash_erase_seq_tb_top;
  localparam int NBLK = 4;
  localparam int WPB = 4;
  localparam int DEPTH = NBLK * WPB;
  localparam int AW = $clog2(DEPTH);
  localparam int ERASE_CYC = 2000;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso;
  logic [NBLK-1:0] prot = '0;
  logic ld_we = 1'b0;
  logic [AW-1:0] ld_addr = '0, rd_addr = '0;
  logic [7:0] ld_data = '0, rd_data;

  always #5 clk = ~clk;

  flash_erase_seq #(.NBLK(NBLK), .WPB(WPB), .BLK_SHIFT(16), .ERASE_CYC(ERASE_CYC)) dut_i (
    .clk(clk), .rst(rst), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi), .spi_miso(miso),
    .blk_protect(prot), .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  int n_chk = 0, n_err = 0;
  bit done = 0;
  logic [7:0] fb [6];
  logic [7:0] rx_last;
  logic [7:0] exp_mem [DEPTH];
  logic exp_wel;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xbit(input logic b);
    mosi = b;
    wait_clk(HALF);
    rx_last = {rx_last[6:0], miso};
    sck = 1'b1;
    wait_clk(HALF);
    sck = 1'b0;
  endtask

  task automatic frame(input int nb, input int xb);
    cs_n = 1'b0;
    wait_clk(HALF);
    for (int b = 0; b < nb; b++)
      for (int i = 7; i >= 0; i--) xbit(fb[b][i]);
    for (int i = 0; i < xb; i++) xbit(1'b1);
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(4 * HALF);
  endtask

  task automatic check_status(input logic [7:0] e, input string req);
    fb[0] = 8'h05; fb[1] = 8'h00;
    frame(2, 0);
    chk(rx_last == e, req, rx_last, e);
  endtask

  task automatic wren();
    fb[0] = 8'h06;
    frame(1, 0);
  endtask

  task automatic set_be(input logic [23:0] a);
    fb[0] = 8'hD8; fb[1] = a[23:16]; fb[2] = a[15:8]; fb[3] = a[7:0]; fb[4] = 8'h5A;
  endtask

  task automatic load_mem(input bit rnd);
    for (int i = 0; i < DEPTH; i++) begin
      logic [7:0] v;
      v = rnd ? 8'($urandom % 255) : 8'(8'h20 + i);
      ld_we = 1'b1; ld_addr = AW'(i); ld_data = v; exp_mem[i] = v;
      wait_clk(1);
    end
    ld_we = 1'b0;
  endtask

  task automatic check_mem(input string req);
    for (int i = 0; i < DEPTH; i++) begin
      rd_addr = AW'(i);
      wait_clk(2);
      chk(rd_data == exp_mem[i], req, rd_data, exp_mem[i]);
    end
  endtask

  function automatic logic [7:0] stat_of(input logic we, input logic busy);
    return {6'b0, we, busy};
  endfunction

  task automatic model_erase_blk(input int b);
    for (int w = 0; w < WPB; w++) exp_mem[b * WPB + w] = 8'hFF;
  endtask

  task automatic model_erase_all();
    for (int i = 0; i < DEPTH; i++) exp_mem[i] = 8'hFF;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired before the end of the test");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    exp_wel = 1'b0;
    wait_clk(6);
    rst = 1'b0;
    wait_clk(4);

    chk(miso == 1'b0, "R1 miso idle", miso, 0);
    check_status(8'h00, "R1 reset status");

    load_mem(0);
    check_mem("R11 load and read");

    // R7: partial write-enable frame rejected
    fb[0] = 8'h06; frame(0, 7);
    check_status(8'h00, "R7 partial WREN");
    fb[0] = 8'h06; fb[1] = 8'h06; frame(2, 0);
    check_status(8'h00, "R7 two-byte WREN");

    // R6: erase without write-enable
    set_be(24'h02_0000); frame(4, 0);
    wait_clk(ERASE_CYC + 50);
    check_status(8'h00, "R6 BE without WEL");
    fb[0] = 8'hC7; frame(1, 0);
    wait_clk(ERASE_CYC + 50);
    check_mem("R6 array untouched");

    // R2
    wren();
    check_status(8'h02, "R2 WREN sets WEL");

    // R7: wrong byte counts and stray bits for block erase
    set_be(24'h02_0000); frame(3, 0);
    check_status(8'h02, "R7 BE short");
    set_be(24'h02_0000); frame(4, 3);
    check_status(8'h02, "R7 BE stray bits");
    set_be(24'h02_0000); frame(5, 0);
    check_status(8'h02, "R7 BE long");
    check_mem("R7 array untouched");

    // R4, R3, R8: block erase of block 2 with timing windows
    set_be(24'h12ABCD); frame(4, 0);
    check_status(8'h03, "R3 status during erase");
    wait_clk(ERASE_CYC - 400 - 4 * HALF - 290);
    check_status(8'h03, "R8 still busy near end");
    wait_clk(150);
    check_status(8'h00, "R8 busy and WEL cleared");
    model_erase_blk(2);
    check_mem("R4 block erase");

    // R10: commands during busy ignored
    load_mem(0);
    wren();
    set_be(24'h01_0000); frame(4, 0);
    wren();
    set_be(24'h00_1234); frame(4, 0);
    fb[0] = 8'h60; frame(1, 0);
    wait_clk(ERASE_CYC + 50);
    check_status(8'h00, "R10 status after busy");
    model_erase_blk(1);
    check_mem("R10 only first erase applied");

    // R9: protected block and protected chip erase
    load_mem(0);
    prot = 4'b0001;
    wren();
    set_be(24'hFC_0007); frame(4, 0);
    check_status(8'h02, "R9 protected BE not run");
    fb[0] = 8'hC7; frame(1, 0);
    wait_clk(ERASE_CYC + 50);
    check_status(8'h02, "R9 protected CE not run");
    check_mem("R9 array untouched");

    // R5: chip erase with both opcodes
    prot = 4'b0000;
    fb[0] = 8'h60; frame(1, 0);
    wait_clk(ERASE_CYC + 50);
    check_status(8'h00, "R5 CE 0x60 status");
    model_erase_all();
    check_mem("R5 CE 0x60 array");
    load_mem(0);
    wren();
    fb[0] = 8'hC7; frame(1, 0);
    wait_clk(ERASE_CYC + 50);
    check_status(8'h00, "R5 CE 0xC7 status");
    model_erase_all();
    check_mem("R5 CE 0xC7 array");
    exp_wel = 1'b0;

    // Random mix over R4 R5 R6 R7 R9
    for (int it = 0; it < 22; it++) begin
      int kind, nb, xb, delta;
      logic [23:0] a;
      logic started;
      load_mem(1);
      prot = ($urandom % 2) ? NBLK'($urandom % 16) : '0;
      if ($urandom % 2) begin wren(); exp_wel = 1'b1; end
      kind = $urandom % 4;
      xb = ($urandom % 4 == 0) ? 1 + $urandom % 7 : 0;
      delta = ($urandom % 5 == 0) ? (($urandom % 2) ? 1 : -1) : 0;
      started = 1'b0;
      a = 24'($urandom);
      case (kind)
        0: begin
          fb[0] = 8'h06; nb = 1 + delta;
          if (nb == 1 && xb == 0) exp_wel = 1'b1;
        end
        1: begin
          set_be(a); nb = 4 + delta;
          started = (nb == 4) && (xb == 0) && exp_wel && !prot[a[17:16]];
        end
        2: begin
          fb[0] = (it % 2) ? 8'hC7 : 8'h60; nb = 1 + delta;
          started = (nb == 1) && (xb == 0) && exp_wel && (prot == '0);
        end
        default: begin
          fb[0] = 8'h05; fb[1] = 8'h00; nb = 2;
        end
      endcase
      frame(nb, xb);
      if (started) begin
        wait_clk(ERASE_CYC + 50);
        if (kind == 1) model_erase_blk(int'(a[17:16]));
        else model_erase_all();
        exp_wel = 1'b0;
      end
      check_status(stat_of(exp_wel, 1'b0), "R7 random status");
      check_mem("R4 random array");
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule